// File: doc/BRIEF.md
# DMA Channel Request Qualifier

This block sits in front of one DMA channel's transfer engine and decides, on every clock, whether that channel may raise a transfer request. A 4-bit source select picks where requests come from. Requests can be generated internally (auto-request), taken from an on-chip peripheral's request line, or sampled from an active-low external request pin. The same select code also tells the engine which addressing scheme to use: dual address, or single address together with a direction.

A request only passes when the channel is permitted to run. The channel enable and the global master enable must both be set, and the address-error and NMI flags must both be clear. The transfer-end flag is handled according to the source and detection style. Auto-requests and edge-detected external requests are blocked while the end flag is set. A level-detected external request may keep running past the end flag when the end-flag mask is set. The external pin is synchronized before any detection. A select code with no defined meaning raises an illegal-configuration output and never lets a request through.

The request strobe `req_valid` is a plain registered control pin. It is not a valid/ready stream, and it needs no back-pressure: the auto-request pulse waits for the engine's `xfer_done` before it re-arms, so requests cannot pile up.

Top module: `dma_req_qual`

## Requirements
- R1: Select code 4'b0000 chooses the external request in dual address mode: `dual_addr`=1, `single_dir`=0, `cfg_illegal`=0.
- R2: Select code 4'b0010 chooses the external request in single address mode, moving from memory to the acknowledged device (`dual_addr`=0, `single_dir`=0). Select code 4'b0011 chooses the same mode in the other direction, from the acknowledged device to memory (`dual_addr`=0, `single_dir`=1).
- R3: Select code 4'b0100 chooses auto-request and select code 4'b1000 chooses the peripheral request. Both are in dual address mode (`dual_addr`=1, `single_dir`=0).
- R4: Every other select code sets `cfg_illegal`=1, `dual_addr`=0 and `single_dir`=0, and `req_valid` stays 0 whatever the other inputs are.
- R5: In auto mode, a request is issued only when `chan_en`=1, `master_en`=1, `end_flag`=0, `addr_err`=0 and `nmi_flag`=0. `req_valid` rises on the clock edge after the conditions are applied.
- R6: The auto request is a single-cycle pulse. After a pulse, no further auto request is issued until `xfer_done` has been seen high on a clock edge. Reset leaves the channel armed.
- R7: In level mode (`edge_mode`=0), `req_valid` is 1 for as long as `ext_req_n` is low and the gating holds. It rises on the third clock edge after `ext_req_n` falls: two synchronizer stages, then one output register.
- R8: In level mode, `chan_en`=1, `master_en`=1, `addr_err`=0 and `nmi_flag`=0 are required. `end_flag` blocks the request only when `end_mask`=0.
- R9: In edge mode (`edge_mode`=1), each falling edge of `ext_req_n` gives exactly one single-cycle pulse on `req_valid`. This happens only if `end_flag`=0 (whatever `end_mask` is) and the other four enable conditions hold.
- R10: A falling edge that arrives while the edge-mode enable conditions are not met is discarded. It does not produce a request later, even after the conditions return.
- R11: In peripheral mode, `req_valid` follows `periph_req` one clock later, gated by the same conditions as auto mode.
- R12: While `rst_n`=0, `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_sel | input | 4 | Request source and address mode select |
| chan_en | input | 1 | Channel enable |
| master_en | input | 1 | Global master enable |
| end_flag | input | 1 | Transfer-end flag |
| end_mask | input | 1 | Lets level-mode requests ignore the transfer-end flag |
| addr_err | input | 1 | Address-error flag |
| nmi_flag | input | 1 | NMI flag |
| edge_mode | input | 1 | External detection: 1 = falling edge, 0 = low level |
| ext_req_n | input | 1 | Asynchronous external request, active low |
| periph_req | input | 1 | On-chip peripheral request, active high, synchronous |
| xfer_done | input | 1 | Engine finished a transfer; re-arms auto-request |
| req_valid | output | 1 | Qualified transfer request strobe |
| dual_addr | output | 1 | 1 = dual address mode |
| single_dir | output | 1 | Single address direction: 1 = device to memory |
| cfg_illegal | output | 1 | Select code has no defined meaning |

## Verification
A wrong internal state shows up at `req_valid` within a few clocks. A stuck auto-arm flag gives either a silent channel or a pulse in two consecutive cycles, seen on the cycle after the first pulse. A broken synchronizer or edge detector moves the pulse away from the third edge after the pin falls, repeats the pulse, or drops it. Gating or decode errors show at the very next edge as a request under forbidden flags or a wrong mode output. The bench sweeps all 64 flag combinations for each source and all 16 select codes, which catches each of these.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_AUTO   = 2'd2,
    SRC_PERIPH = 2'd3
  } src_e;

  localparam logic [SEL_W-1:0] CODE_EXT_DUAL   = 4'b0000;
  localparam logic [SEL_W-1:0] CODE_EXT_TO_DEV = 4'b0010;
  localparam logic [SEL_W-1:0] CODE_EXT_TO_MEM = 4'b0011;
  localparam logic [SEL_W-1:0] CODE_AUTO       = 4'b0100;
  localparam logic [SEL_W-1:0] CODE_PERIPH     = 4'b1000;
endpackage

// File: rtl/dmaq_sel_decode.sv
module dmaq_sel_decode
  import dmaq_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output src_e             src,
  output logic             dual,
  output logic             dir_to_mem,
  output logic             illegal
);
  always_comb begin
    src        = SRC_NONE;
    dual       = 1'b0;
    dir_to_mem = 1'b0;
    illegal    = 1'b0;
    unique case (sel)
      CODE_EXT_DUAL:   begin src = SRC_EXT;    dual = 1'b1; end
      CODE_EXT_TO_DEV: begin src = SRC_EXT; end
      CODE_EXT_TO_MEM: begin src = SRC_EXT;    dir_to_mem = 1'b1; end
      CODE_AUTO:       begin src = SRC_AUTO;   dual = 1'b1; end
      CODE_PERIPH:     begin src = SRC_PERIPH; dual = 1'b1; end
      default:         illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dmaq_gate.sv
module dmaq_gate (
  input  logic chan_en,
  input  logic master_en,
  input  logic end_flag,
  input  logic end_mask,
  input  logic addr_err,
  input  logic nmi_flag,
  input  logic edge_mode,
  output logic ok_strict,
  output logic ok_ext
);
  logic base_ok;

  always_comb begin
    base_ok   = chan_en & master_en & ~addr_err & ~nmi_flag;
    ok_strict = base_ok & ~end_flag;
    // level detection may run past the end flag when masked
    ok_ext    = edge_mode ? ok_strict : (base_ok & (end_mask | ~end_flag));
  end
endmodule

// File: rtl/dmaq_ext_sampler.sv
module dmaq_ext_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low_level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= pin_n;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];
  end

  assign low_level = ~chain[STAGES-1];
  assign fall      = last_q & ~chain[STAGES-1];

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual
  import dmaq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] req_sel,
  input  logic             chan_en,
  input  logic             master_en,
  input  logic             end_flag,
  input  logic             end_mask,
  input  logic             addr_err,
  input  logic             nmi_flag,
  input  logic             edge_mode,
  input  logic             ext_req_n,
  input  logic             periph_req,
  input  logic             xfer_done,
  output logic             req_valid,
  output logic             dual_addr,
  output logic             single_dir,
  output logic             cfg_illegal
);
  src_e src;
  logic ok_strict, ok_ext;
  logic ext_low, ext_fall;
  logic armed_q;
  logic fire_auto, fire_ext, fire_per, fire;

  dmaq_sel_decode u_dec (
    .sel(req_sel), .src(src), .dual(dual_addr),
    .dir_to_mem(single_dir), .illegal(cfg_illegal)
  );

  dmaq_gate u_gate (
    .chan_en(chan_en), .master_en(master_en), .end_flag(end_flag),
    .end_mask(end_mask), .addr_err(addr_err), .nmi_flag(nmi_flag),
    .edge_mode(edge_mode), .ok_strict(ok_strict), .ok_ext(ok_ext)
  );

  dmaq_ext_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_req_n),
    .low_level(ext_low), .fall(ext_fall)
  );

  always_comb begin
    fire_auto = (src == SRC_AUTO) & ok_strict & armed_q;
    fire_per  = (src == SRC_PERIPH) & ok_strict & periph_req;
    // an edge seen while gated is dropped, never held over
    fire_ext  = (src == SRC_EXT) & ok_ext & (edge_mode ? ext_fall : ext_low);
    fire      = fire_auto | fire_per | fire_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         armed_q <= 1'b1;
    else if (fire_auto) armed_q <= 1'b0;
    else if (xfer_done) armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_valid <= 1'b0;
    else        req_valid <= fire;
  end

  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_illegal) |-> !req_valid);

  // R5
  base_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(chan_en && master_en && !addr_err && !nmi_flag));

  // R9
  edge_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(src == SRC_EXT && edge_mode)) |-> !$past(end_flag));

  // R6
  auto_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(src == SRC_AUTO) && $past(src == SRC_AUTO, 2))
      |-> !$past(req_valid));
endmodule

// File: tb/dma_req_qual_bench.sv
module dma_req_qual_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req_sel;
  logic       chan_en, master_en, end_flag, end_mask, addr_err, nmi_flag;
  logic       edge_mode, ext_req_n, periph_req, xfer_done;
  logic       req_valid, dual_addr, single_dir, cfg_illegal;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  dma_req_qual u_dma_req_qual (
    .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .chan_en(chan_en),
    .master_en(master_en), .end_flag(end_flag), .end_mask(end_mask),
    .addr_err(addr_err), .nmi_flag(nmi_flag), .edge_mode(edge_mode),
    .ext_req_n(ext_req_n), .periph_req(periph_req), .xfer_done(xfer_done),
    .req_valid(req_valid), .dual_addr(dual_addr), .single_dir(single_dir),
    .cfg_illegal(cfg_illegal)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_flags(input logic [5:0] f);
    chan_en   = f[0];
    master_en = f[1];
    end_flag  = f[2];
    end_mask  = f[3];
    addr_err  = f[4];
    nmi_flag  = f[5];
  endtask

  function automatic int gate_strict(input logic [5:0] f);
    return int'(f[0] & f[1] & ~f[2] & ~f[4] & ~f[5]);
  endfunction

  function automatic int gate_level(input logic [5:0] f);
    return int'(f[0] & f[1] & ~f[4] & ~f[5] & (f[3] | ~f[2]));
  endfunction

  initial begin
    #4_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; req_sel = 4'b0000; set_flags(6'b000011);
    edge_mode = 1'b0; ext_req_n = 1'b1; periph_req = 1'b0; xfer_done = 1'b0;
    step(3);
    check("R12 reset req_valid", int'(req_valid), 0);
    rst_n = 1'b1;
    step(4);

    // R1 R2 R3 R4: decode sweep over all codes, everything else pushing a request
    set_flags(6'b001011); periph_req = 1'b1; ext_req_n = 1'b0; xfer_done = 1'b1;
    for (int c = 0; c < 16; c++) begin
      int legal, edual, edir;
      req_sel = 4'(c);
      legal = (c == 0 || c == 2 || c == 3 || c == 4 || c == 8) ? 1 : 0;
      edual = (c == 0 || c == 4 || c == 8) ? 1 : 0;
      edir  = (c == 3) ? 1 : 0;
      step(2);
      check($sformatf("R4 illegal code %0d", c), int'(cfg_illegal), 1 - legal);
      check($sformatf("R1 R3 dual code %0d", c), int'(dual_addr), edual);
      check($sformatf("R2 dir code %0d", c), int'(single_dir), edir);
      if (!legal) check($sformatf("R4 quiet code %0d", c), int'(req_valid), 0);
    end
    periph_req = 1'b0; ext_req_n = 1'b1; xfer_done = 1'b0;
    req_sel = 4'b0000; step(4);

    // R5 R6: auto sweep
    for (int i = 0; i < 64; i++) begin
      int g;
      g = gate_strict(6'(i));
      req_sel = 4'b0000; xfer_done = 1'b1; step(1);
      xfer_done = 1'b0; set_flags(6'(i)); req_sel = 4'b0100;
      step(1);
      check($sformatf("R5 auto flags %0d", i), int'(req_valid), g);
      step(1);
      check($sformatf("R6 auto no repeat flags %0d", i), int'(req_valid), 0);
      step(2);
      check($sformatf("R6 auto stays idle flags %0d", i), int'(req_valid), 0);
      if (g == 1) begin
        xfer_done = 1'b1; step(1); xfer_done = 1'b0;
        step(1);
        check($sformatf("R6 auto rearm flags %0d", i), int'(req_valid), 1);
      end
    end
    req_sel = 4'b0000; step(2);

    // R11: peripheral sweep
    req_sel = 4'b1000;
    for (int i = 0; i < 64; i++) begin
      set_flags(6'(i)); periph_req = 1'b1; step(1);
      check($sformatf("R11 periph flags %0d", i), int'(req_valid), gate_strict(6'(i)));
      periph_req = 1'b0; step(1);
      check($sformatf("R11 periph idle flags %0d", i), int'(req_valid), 0);
    end

    // R7: level latency
    req_sel = 4'b0010; edge_mode = 1'b0; set_flags(6'b000011);
    step(4);
    ext_req_n = 1'b0;
    step(2);
    check("R7 level not yet after two edges", int'(req_valid), 0);
    step(1);
    check("R7 level up on third edge", int'(req_valid), 1);
    step(5);
    check("R7 level held", int'(req_valid), 1);

    // R8: level sweep with the pin held low
    for (int i = 0; i < 64; i++) begin
      set_flags(6'(i)); step(1);
      check($sformatf("R8 level flags %0d", i), int'(req_valid), gate_level(6'(i)));
    end
    set_flags(6'b000011);
    ext_req_n = 1'b1; step(2);
    check("R7 level still up", int'(req_valid), 1);
    step(1);
    check("R7 level released", int'(req_valid), 0);

    // R9: edge sweep, count pulses per falling edge
    req_sel = 4'b0011; edge_mode = 1'b1;
    for (int i = 0; i < 64; i++) begin
      set_flags(6'(i)); ext_req_n = 1'b1; step(4);
      ext_req_n = 1'b0; cnt = 0;
      for (int k = 0; k < 8; k++) begin
        step(1);
        if (req_valid) cnt++;
      end
      check($sformatf("R9 edge pulses flags %0d", i), cnt, gate_strict(6'(i)));
    end

    // R9: pulse timing
    set_flags(6'b000011); ext_req_n = 1'b1; step(4);
    ext_req_n = 1'b0; step(2);
    check("R9 edge not before third edge", int'(req_valid), 0);
    step(1);
    check("R9 edge on third edge", int'(req_valid), 1);
    step(1);
    check("R9 edge single cycle", int'(req_valid), 0);

    // R10: an edge that arrives while gated is dropped
    ext_req_n = 1'b1; step(4);
    set_flags(6'b000001);
    ext_req_n = 1'b0; step(4);
    set_flags(6'b000011); cnt = 0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      if (req_valid) cnt++;
    end
    check("R10 gated edge dropped", cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule